// File: doc/BRIEF.md
# Fault Collection and Attention Routing Register Block

This block gathers thirteen independent hardware error lines into a sticky fault vector. Each line reports its own failure kind, for example a parity fault, an access to an address with no register behind it, a queue overflow, two start requests that conflict, or a configuration mistake. A mask vector stops selected faults from raising attention. Four class-routing vectors decide which of the unmasked faults drive each of the four attention outputs: chip checkstop, recoverable, special attention and unit checkstop.

Software reaches the block through a small word-addressed register port. The port has an address, a write strobe, write data and combinational read data. The fault and mask vectors each have a second, write-only address. A write there ORs the data in, so bits are set without a read-modify-write. A write to the primary address clears every bit written as zero. The block also notes, as a one-hot value, which fault was the first to arrive into an empty fault vector. On that same event it fills two report registers.

Top module: `fault_attn_hub`

## Requirements
- R1: After synchronous reset every register reads zero and all four attention outputs are low.
- R2: A fault bit is set on the clock edge at which its error input is high. It can be read one cycle later, and it stays set after the input drops until software clears it.
- R3: A write to offset 0x0 clears each fault bit whose write-data bit is 0 and keeps each bit written as 1. A read of 0x0 returns the fault vector.
- R4: A write to offset 0x1 ORs the write data into the fault vector. Reads of offsets 0x1 and 0x3 return zero.
- R5: A write to offset 0x2 clears each mask bit written as 0. A write to offset 0x3 ORs the write data into the mask. A read of 0x2 returns the mask.
- R6: Offsets 0x4, 0x5, 0x6 and 0x7 hold the routing vectors for attn[0] (chip checkstop), attn[1] (recoverable), attn[2] (special attention) and attn[3] (unit checkstop). They are written directly and read back.
- R7: attn[c] is high exactly when (fault AND NOT mask AND route[c]) has a bit set. It follows a register change in the next cycle.
- R8: If an error input is high in the same cycle that a software write would clear or leave that fault bit at zero, the bit is set.
- R9: When the fault vector is all zero and at least one bit becomes set, offset 0x8 captures a one-hot copy of the lowest-indexed new bit. While the fault vector is non-zero it does not change, and any write to 0x8 clears it.
- R10: On the same event as R9, offset 0xC captures the new fault vector and offset 0xE captures the mask vector. Any write to either offset clears that register.
- R11: Reads of unmapped offsets 0x9, 0xA, 0xB, 0xD and 0xF return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Word offset for read and write |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 13 | Write data |
| reg_rdata | output | 13 | Read data for reg_addr (combinational) |
| err_in | input | 13 | Hardware error lines, one per fault bit |
| attn | output | 4 | Attention per class: [0] chip checkstop, [1] recoverable, [2] special, [3] unit checkstop |

## Verification
A fault bit that is lost or wrongly set shows up in two places one cycle after the edge: in the read of offset 0x0, and on every attention output whose routing vector covers that bit while the mask leaves it open. A broken mask or routing path makes the attention vector disagree with the register contents. It does so as soon as the registers settle, so the bench compares the attention outputs on every read. An error in the first-arrival or report capture stays hidden until offsets 0x8, 0xC or 0xE are read. Those reads are therefore placed right after each empty-to-non-empty transition and after later faults that must leave the captured values unchanged.

// File: rtl/fir_pkg.sv
package fir_pkg;
    localparam int N_ERR   = 13;
    localparam int N_CLASS = 4;
    localparam int ADDR_W  = 4;

    typedef logic [N_ERR-1:0]  errvec_t;
    typedef logic [ADDR_W-1:0] off_t;

    localparam off_t OFF_FAULT     = 4'h0;
    localparam off_t OFF_FAULT_SET = 4'h1;
    localparam off_t OFF_MASK      = 4'h2;
    localparam off_t OFF_MASK_SET  = 4'h3;
    localparam off_t OFF_ROUTE0    = 4'h4;
    localparam off_t OFF_FIRST     = 4'h8;
    localparam off_t OFF_RPT0      = 4'hC;
    localparam off_t OFF_RPT1      = 4'hE;

    typedef struct packed {
        logic               fault_clr;
        logic               fault_set;
        logic               mask_clr;
        logic               mask_set;
        logic [N_CLASS-1:0] route_wr;
        logic               first_clr;
        logic               rpt0_clr;
        logic               rpt1_clr;
    } wr_dec_t;

    function automatic errvec_t lowest_set(input errvec_t v);
        return v & (~v + errvec_t'(1));
    endfunction
endpackage

// File: rtl/fir_sticky_reg.sv
module fir_sticky_reg
    import fir_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr_en,
    input  logic    set_en,
    input  errvec_t wdata,
    input  errvec_t hw_set,
    output errvec_t q,
    output errvec_t d
);
    always_comb begin
        d = q;
        if (clr_en) d = d & wdata;
        if (set_en) d = d | wdata;
        d = d | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !clr_en |=> ((q & $past(q)) == $past(q)));  // R2
    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|hw_set) |=> ((q & $past(hw_set)) == $past(hw_set)));  // R8
    AST_OR_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((q & $past(wdata)) == $past(wdata)));  // R4
endmodule

// File: rtl/fir_first_capture.sv
module fir_first_capture
    import fir_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  errvec_t fault_q,
    input  errvec_t fault_d,
    input  errvec_t mask_q,
    input  logic    first_clr,
    input  logic    rpt0_clr,
    input  logic    rpt1_clr,
    output errvec_t first_q,
    output errvec_t rpt0_q,
    output errvec_t rpt1_q
);
    logic arrive;
    assign arrive = (fault_q == '0) && (fault_d != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= '0;
            rpt0_q  <= '0;
            rpt1_q  <= '0;
        end else if (arrive) begin
            first_q <= lowest_set(fault_d);
            rpt0_q  <= fault_d;
            rpt1_q  <= mask_q;
        end else begin
            if (first_clr) first_q <= '0;
            if (rpt0_clr)  rpt0_q  <= '0;
            if (rpt1_clr)  rpt1_q  <= '0;
        end
    end

    AST_FIRST_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(first_q));  // R9
    AST_FIRST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ((fault_q != '0) && !first_clr) |=> $stable(first_q));  // R9
    AST_RPT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ((fault_q != '0) && !rpt0_clr) |=> $stable(rpt0_q));  // R10
endmodule

// File: rtl/fir_attn_router.sv
module fir_attn_router
    import fir_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [N_CLASS-1:0]             route_wr,
    input  errvec_t                        wdata,
    input  errvec_t                        fault_q,
    input  errvec_t                        mask_q,
    output logic [N_CLASS-1:0][N_ERR-1:0]  route_q,
    output logic [N_CLASS-1:0]             attn
);
    errvec_t live;
    assign live = fault_q & ~mask_q;

    for (genvar c = 0; c < N_CLASS; c++) begin : g_class
        always_ff @(posedge clk) begin
            if (rst)              route_q[c] <= '0;
            else if (route_wr[c]) route_q[c] <= wdata;
        end
        assign attn[c] = |(live & route_q[c]);
    end

    AST_ATTN_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((fault_q & ~mask_q) == '0) |-> (attn == '0));  // R7
endmodule

// File: rtl/fault_attn_hub.sv
module fault_attn_hub
    import fir_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_we,
    input  logic [N_ERR-1:0]      reg_wdata,
    output logic [N_ERR-1:0]      reg_rdata,
    input  logic [N_ERR-1:0]      err_in,
    output logic [N_CLASS-1:0]    attn
);
    wr_dec_t dec;
    errvec_t fault_q, fault_d, mask_q, mask_d;
    errvec_t first_q, rpt0_q, rpt1_q;
    logic [N_CLASS-1:0][N_ERR-1:0] route_q;

    always_comb begin
        dec = '0;
        if (reg_we) begin
            dec.fault_clr = (reg_addr == OFF_FAULT);
            dec.fault_set = (reg_addr == OFF_FAULT_SET);
            dec.mask_clr  = (reg_addr == OFF_MASK);
            dec.mask_set  = (reg_addr == OFF_MASK_SET);
            dec.first_clr = (reg_addr == OFF_FIRST);
            dec.rpt0_clr  = (reg_addr == OFF_RPT0);
            dec.rpt1_clr  = (reg_addr == OFF_RPT1);
            for (int c = 0; c < N_CLASS; c++)
                dec.route_wr[c] = (reg_addr == OFF_ROUTE0 + off_t'(c));
        end
    end

    fir_sticky_reg u_fault (
        .clk(clk), .rst(rst),
        .clr_en(dec.fault_clr), .set_en(dec.fault_set),
        .wdata(reg_wdata), .hw_set(err_in),
        .q(fault_q), .d(fault_d)
    );

    fir_sticky_reg u_mask (
        .clk(clk), .rst(rst),
        .clr_en(dec.mask_clr), .set_en(dec.mask_set),
        .wdata(reg_wdata), .hw_set('0),
        .q(mask_q), .d(mask_d)
    );

    fir_first_capture u_first (
        .clk(clk), .rst(rst),
        .fault_q(fault_q), .fault_d(fault_d), .mask_q(mask_q),
        .first_clr(dec.first_clr), .rpt0_clr(dec.rpt0_clr), .rpt1_clr(dec.rpt1_clr),
        .first_q(first_q), .rpt0_q(rpt0_q), .rpt1_q(rpt1_q)
    );

    fir_attn_router u_route (
        .clk(clk), .rst(rst),
        .route_wr(dec.route_wr), .wdata(reg_wdata),
        .fault_q(fault_q), .mask_q(mask_q),
        .route_q(route_q), .attn(attn)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_FAULT: reg_rdata = fault_q;
            OFF_MASK:  reg_rdata = mask_q;
            OFF_FIRST: reg_rdata = first_q;
            OFF_RPT0:  reg_rdata = rpt0_q;
            OFF_RPT1:  reg_rdata = rpt1_q;
            default: begin
                for (int c = 0; c < N_CLASS; c++)
                    if (reg_addr == OFF_ROUTE0 + off_t'(c)) reg_rdata = route_q[c];
            end
        endcase
    end

    logic unused_mask_d;
    assign unused_mask_d = |mask_d;

    AST_ALIAS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((reg_addr == OFF_FAULT_SET) || (reg_addr == OFF_MASK_SET)) |-> (reg_rdata == '0));  // R4
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (attn == '0));  // R1
endmodule

// File: tb/fault_attn_hub_bench.sv
module fault_attn_hub_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [12:0] reg_wdata = '0;
    logic [12:0] reg_rdata;
    logic [12:0] err_in = '0;
    logic [3:0]  attn;

    always #10 clk = ~clk;

    fault_attn_hub u_fault_attn_hub (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_in(err_in), .attn(attn)
    );

    typedef struct {
        logic [3:0]  addr;
        logic [12:0] data;
        logic [3:0]  attn;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            compared++;
            if (reg_rdata !== it.data || attn !== it.attn) begin
                mismatched++;
                $display("FAIL %s addr=%h rdata=%h attn=%b expected rdata=%h attn=%b",
                         it.tag, it.addr, reg_rdata, attn, it.data, it.attn);
            end
        end
    end

    task automatic rd(input logic [3:0] a, input logic [12:0] d, input logic [3:0] at, input string tag);
        item_t it;
        @(posedge clk); #1;
        reg_addr = a;
        it.addr = a; it.data = d; it.attn = at; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic wr_err(input logic [3:0] a, input logic [12:0] d, input logic [12:0] e);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_we = 1'b1; err_in = e;
        @(posedge clk); #1;
        reg_we = 1'b0; err_in = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [12:0] d);
        wr_err(a, d, '0);
    endtask

    task automatic pulse(input logic [12:0] e);
        @(posedge clk); #1;
        err_in = e;
        @(posedge clk); #1;
        err_in = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 and R11: everything reads zero after reset
        for (int a = 0; a < 16; a++) rd(4'(a), 13'h0, 4'b0000, "R1/R11 reset");

        pulse(13'h0008);
        rd(4'h0, 13'h0008, 4'b0000, "R2 sticky after input drop");
        wr(4'h5, 13'h1FFF);
        rd(4'h5, 13'h1FFF, 4'b0010, "R6 route readback");
        rd(4'h4, 13'h0000, 4'b0010, "R6 other route untouched");
        rd(4'h8, 13'h0008, 4'b0010, "R9 first one-hot");
        rd(4'hC, 13'h0008, 4'b0010, "R10 report0 capture");
        rd(4'hE, 13'h0000, 4'b0010, "R10 report1 mask capture");

        pulse(13'h00A0);
        rd(4'h0, 13'h00A8, 4'b0010, "R2 accumulate");
        rd(4'h8, 13'h0008, 4'b0010, "R9 first frozen");
        rd(4'hC, 13'h0008, 4'b0010, "R10 report frozen");

        wr(4'h3, 13'h00A8);
        rd(4'h2, 13'h00A8, 4'b0000, "R5 mask or-set / R7 masked");
        rd(4'h3, 13'h0000, 4'b0000, "R4 mask alias reads zero");
        wr(4'h2, 13'h1FF7);
        rd(4'h2, 13'h00A0, 4'b0010, "R5 mask and-clear / R7 unmasked");
        wr(4'h0, 13'h1FF7);
        rd(4'h0, 13'h00A0, 4'b0000, "R3 fault and-clear / R7");
        wr(4'h1, 13'h1000);
        rd(4'h0, 13'h10A0, 4'b0010, "R4 fault or-set");
        rd(4'h1, 13'h0000, 4'b0010, "R4 fault alias reads zero");
        rd(4'h8, 13'h0008, 4'b0010, "R9 first frozen after or-set");

        wr_err(4'h0, 13'h0000, 13'h0020);
        rd(4'h0, 13'h0020, 4'b0000, "R8 hardware set wins");

        wr(4'h8, 13'h1FFF);
        wr(4'hC, 13'h0000);
        wr(4'hE, 13'h0000);
        rd(4'h8, 13'h0000, 4'b0000, "R9 first cleared by write");
        rd(4'hC, 13'h0000, 4'b0000, "R10 report0 cleared");
        rd(4'hE, 13'h0000, 4'b0000, "R10 report1 cleared");

        wr(4'h0, 13'h0000);
        rd(4'h0, 13'h0000, 4'b0000, "R3 full clear");
        pulse(13'h0C00);
        rd(4'h8, 13'h0400, 4'b0010, "R9 lowest index wins");
        rd(4'hC, 13'h0C00, 4'b0010, "R10 report0 new vector");
        rd(4'hE, 13'h00A0, 4'b0010, "R10 report1 mask snapshot");

        wr(4'h4, 13'h0400);
        wr(4'h6, 13'h0800);
        wr(4'h7, 13'h0000);
        rd(4'h6, 13'h0800, 4'b0111, "R6/R7 class routing");
        rd(4'h7, 13'h0000, 4'b0111, "R6 unit route");
        rd(4'h9, 13'h0000, 4'b0111, "R11 unmapped 0x9");
        rd(4'hD, 13'h0000, 4'b0111, "R11 unmapped 0xD");
        rd(4'hF, 13'h0000, 4'b0111, "R11 unmapped 0xF");
        wr(4'h3, 13'h0400);
        rd(4'h0, 13'h0C00, 4'b0110, "R7 chip class masked");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule